// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block works out the effective address and the updated pointer for one data access per cycle on behalf of an address-generation stage. Its main job is to reorder data for radix-2 FFTs. It does this by stepping a chosen pointer register with a reverse-carry addition of a fixed modifier, so that consecutive writes land at bit-reversed positions of a buffer. Accesses that do not qualify get ordinary pre/post increment or decrement addressing. Those accesses can also get modulo (circular buffer) correction.

A small control register holds the reversal enable and the modifier. The modifier is counted in words, and it is usually half the buffer length: 0x0008 for a 16-word buffer. A buffer of 2^N bytes must start at an address whose low N bits are zero. When reversal and modulo are both set up for the same register, reversal wins on writes. Reads through that register keep their modulo correction.

Top module: `bitrev_agu`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge produces `outValid`, `eaOut`, `wbEn` and `wbPtr` after that same edge. A cycle without a request leaves `outValid` and `wbEn` low. After reset, `outValid`, `wbEn`, `eaOut` and `wbPtr` are all zero and reversal is disabled.
- R2: When `ctrlWr` is high, the control register is loaded from `ctrlData`. Bit 15 is the reversal enable and bits 14:0 are the modifier in words. A request in the same cycle as a control write still uses the previous control value.
- R3: Reversal applies only when all of these hold: the enable is set, `isWrite` is high, `isByte` is low, `modeSel` is 2 or 4, and `ptrIdx` equals `selReg`. In any other case the block produces normal addresses.
- R4: Under reversal, the new pointer is the reverse-carry sum of the pointer's word field (bits 15:1) and the modifier. Carries propagate from bit 15 toward bit 1, and bit 0 of the result is 0. The normal step size is ignored. Starting at 0 with modifier 8, successive pointers are the byte addresses of words 0, 8, 4, 12, 2, 10, 6, 14, 1, ...
- R5: Under reversal, `eaOut` is the new pointer for pre-increment (mode 4). For post-increment (mode 2) it is the old pointer with bit 0 cleared.
- R6: In normal addressing the step is 2 for word accesses and 1 for byte accesses. The modes are: 1 post-decrement, 2 post-increment, 3 pre-decrement, 4 pre-increment. Post modes output the old pointer as `eaOut`, pre modes output the new pointer. `wbEn` is high and `wbPtr` carries the new pointer.
- R7: Mode 0 (plain indirect) and the unused codes 5 to 7 output `eaOut` equal to `ptrVal` with `wbEn` low.
- R8: Modulo correction applies when `modEn` is high and `ptrIdx` equals `selReg`, on any access that is not reversed. If an increment produces a value greater than `modHi`, the buffer length `modHi-modLo+1` is subtracted. If a decrement produces a value less than `modLo`, that length is added. A value that lands exactly on a bound is left unchanged.
- R9: A write that qualifies for reversal gets no modulo correction, even with `modEn` high. A read with the same settings is modulo-corrected.
- R10: Register 15 (the stack pointer) is never bit-reversed. With `selReg` = 15, every access gets normal addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWr | input | 1 | Load the reversal control register |
| ctrlData | input | 16 | Control value: bit 15 enable, bits 14:0 modifier in words |
| reqValid | input | 1 | An access is presented this cycle |
| isWrite | input | 1 | Access is a data write (low: read) |
| isByte | input | 1 | Access is byte sized (low: word) |
| modeSel | input | 3 | Addressing mode code |
| ptrIdx | input | 4 | Index of the pointer register used by this access |
| ptrVal | input | 16 | Current contents of that pointer register |
| selReg | input | 4 | Register selected for reversal and modulo handling |
| modEn | input | 1 | Modulo addressing enabled for the selected register |
| modLo | input | 16 | Modulo buffer lower bound (byte address) |
| modHi | input | 16 | Modulo buffer upper bound (byte address) |
| outValid | output | 1 | Result registers hold a fresh result |
| eaOut | output | 16 | Effective address of the access |
| wbEn | output | 1 | Pointer write-back strobe |
| wbPtr | output | 16 | Updated pointer value to write back |

## Verification
The bench walks a full 16-word reversal cycle and checks that it returns to its start. A forward-carry adder would instead produce a linear sequence. It also uses an odd starting pointer, to catch a design that leaks bit 0 into the address. Byte writes, reads, decrements, a non-selected register and register 15 are each sent with reversal enabled; a wrongly gated design would reverse one of them. Modulo cases cover a jump past the upper bound, a landing exactly on a bound, and a wrap below the lower bound, to catch equality-only comparisons. A control write that shares a cycle with a request, and a reversed write beside a modulo-corrected read, expose wrong timing and wrong priority.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;

  localparam logic [2:0] AM_IND     = 3'd0;
  localparam logic [2:0] AM_POSTDEC = 3'd1;
  localparam logic [2:0] AM_POSTINC = 3'd2;
  localparam logic [2:0] AM_PREDEC  = 3'd3;
  localparam logic [2:0] AM_PREINC  = 3'd4;

  typedef struct packed {
    logic fire;    // request accepted this cycle
    logic revOn;   // reverse-carry update chosen
    logic modOn;   // modulo correction chosen
    logic modify;  // pointer is updated and written back
    logic pre;     // address uses the updated pointer
    logic down;    // decrementing mode
    logic byteSz;  // byte step
  } strobe_t;

endpackage

// File: rtl/bitrev_ctrl.sv
module bitrev_ctrl
  import bitrev_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic [AW-1:0] ctrlData,
  input  logic          reqValid,
  input  logic          isWrite,
  input  logic          isByte,
  input  logic [2:0]    modeSel,
  input  logic [IW-1:0] ptrIdx,
  input  logic [IW-1:0] selReg,
  input  logic          modEn,
  output strobe_t       stb,
  output logic [AW-2:0] xbOut
);

  logic          revEnQ;
  logic [AW-2:0] xbQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      revEnQ <= 1'b0;
      xbQ    <= '0;
    end else if (ctrlWr) begin
      revEnQ <= ctrlData[AW-1];
      xbQ    <= ctrlData[AW-2:0];
    end
  end

  assign xbOut = xbQ;

  logic incMode, selHit, stackSel, modeKnown;

  always_comb begin
    incMode   = (modeSel == AM_POSTINC) || (modeSel == AM_PREINC);
    modeKnown = (modeSel >= AM_POSTDEC) && (modeSel <= AM_PREINC);
    selHit    = (ptrIdx == selReg);
    stackSel  = &selReg;

    stb        = '0;
    stb.fire   = reqValid;
    stb.revOn  = reqValid && revEnQ && isWrite && !isByte && incMode
                 && selHit && !stackSel;
    stb.modOn  = reqValid && modEn && selHit && !stb.revOn;
    stb.modify = modeKnown;
    stb.pre    = (modeSel == AM_PREDEC) || (modeSel == AM_PREINC);
    stb.down   = (modeSel == AM_POSTDEC) || (modeSel == AM_PREDEC);
    stb.byteSz = isByte;
  end

endmodule

// File: rtl/bitrev_dp.sv
module bitrev_dp
  import bitrev_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-2:0] xb,
  input  logic [AW-1:0] ptrVal,
  input  logic [AW-1:0] modLo,
  input  logic [AW-1:0] modHi,
  output logic          outValid,
  output logic [AW-1:0] eaOut,
  output logic          wbEn,
  output logic [AW-1:0] wbPtr
);

  localparam int WW = AW - 1;

  function automatic logic [WW-1:0] flip(input logic [WW-1:0] v);
    logic [WW-1:0] r;
    for (int i = 0; i < WW; i++) r[i] = v[WW-1-i];
    return r;
  endfunction

  logic [AW-1:0] step, linPtr, modLen, corrPtr, revPtr, newPtr, eaNext;
  logic [WW-1:0] revSum;

  always_comb begin
    step    = stb.byteSz ? AW'(1) : AW'(2);
    linPtr  = stb.down ? (ptrVal - step) : (ptrVal + step);
    modLen  = modHi - modLo + AW'(1);
    corrPtr = linPtr;
    if (stb.modOn && !stb.down && (linPtr > modHi)) corrPtr = linPtr - modLen;
    if (stb.modOn &&  stb.down && (linPtr < modLo)) corrPtr = linPtr + modLen;

    revSum  = flip(flip(ptrVal[AW-1:1]) + flip(xb));
    revPtr  = {revSum, 1'b0};

    newPtr  = stb.revOn ? revPtr : corrPtr;
    if (!stb.modify) newPtr = ptrVal;
    eaNext  = stb.pre ? newPtr : ptrVal;
    if (stb.revOn) eaNext[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wbEn     <= 1'b0;
      eaOut    <= '0;
      wbPtr    <= '0;
    end else begin
      outValid <= stb.fire;
      wbEn     <= stb.fire && stb.modify;
      if (stb.fire) begin
        eaOut <= eaNext;
        wbPtr <= newPtr;
      end
    end
  end

endmodule

// File: rtl/bitrev_agu.sv
module bitrev_agu
  import bitrev_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic [AW-1:0] ctrlData,
  input  logic          reqValid,
  input  logic          isWrite,
  input  logic          isByte,
  input  logic [2:0]    modeSel,
  input  logic [IW-1:0] ptrIdx,
  input  logic [AW-1:0] ptrVal,
  input  logic [IW-1:0] selReg,
  input  logic          modEn,
  input  logic [AW-1:0] modLo,
  input  logic [AW-1:0] modHi,
  output logic          outValid,
  output logic [AW-1:0] eaOut,
  output logic          wbEn,
  output logic [AW-1:0] wbPtr
);

  strobe_t       stb;
  logic [AW-2:0] xb;

  bitrev_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .reqValid(reqValid), .isWrite(isWrite), .isByte(isByte),
    .modeSel(modeSel), .ptrIdx(ptrIdx), .selReg(selReg), .modEn(modEn),
    .stb(stb), .xbOut(xb)
  );

  bitrev_dp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .xb(xb), .ptrVal(ptrVal),
    .modLo(modLo), .modHi(modHi), .outValid(outValid), .eaOut(eaOut),
    .wbEn(wbEn), .wbPtr(wbPtr)
  );

endmodule

// File: rtl/bitrev_chk.sv
module bitrev_chk #(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          isByte,
  input logic          isWrite,
  input logic [2:0]    modeSel,
  input logic [IW-1:0] selReg,
  input logic          outValid,
  input logic          wbEn,
  input logic [AW-1:0] eaOut,
  input logic          revOn,
  input logic          modOn
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && !wbEn));
  a_r3_byte_not_rev: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (isByte || !isWrite)) |-> !revOn);
  a_r10_stack_not_rev: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (&selReg)) |-> !revOn);
  a_r5_rev_lsb_zero: assert property (@(posedge clk) disable iff (!rstN)
    revOn |=> !eaOut[0]);
  a_r9_rev_beats_mod: assert property (@(posedge clk) disable iff (!rstN)
    revOn |-> !modOn);
  a_r7_plain_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (modeSel == 3'd0 || modeSel > 3'd4)) |=> !wbEn);

endmodule

bind bitrev_agu bitrev_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .isByte(isByte),
  .isWrite(isWrite), .modeSel(modeSel), .selReg(selReg),
  .outValid(outValid), .wbEn(wbEn), .eaOut(eaOut),
  .revOn(stb.revOn), .modOn(stb.modOn)
);

// File: tb/sim_bitrev_agu.sv
`timescale 1ns/1ps
module sim_bitrev_agu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [15:0] ctrlData = '0;
  logic        reqValid = 1'b0, isWrite = 1'b0, isByte = 1'b0, modEn = 1'b0;
  logic [2:0]  modeSel = '0;
  logic [3:0]  ptrIdx = '0, selReg = '0;
  logic [15:0] ptrVal = '0, modLo = '0, modHi = '0;
  logic        outValid, wbEn;
  logic [15:0] eaOut, wbPtr;

  always #5 clk = ~clk;

  bitrev_agu u0 (.*);

  typedef struct {
    logic [15:0] ea;
    logic        wb;
    logic [15:0] ptr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   tests = 0, fails = 0;
  logic mEn = 1'b0;
  logic [14:0] mXb = '0;
  logic [15:0] lastWb;

  // reverse-carry sum: carry moves from bit 15 down to bit 1
  function automatic logic [15:0] rcAdd(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] s;
    logic c;
    s = '0;
    c = 1'b0;
    for (int i = 15; i >= 1; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  task automatic issue(input logic w, input logic by, input logic [2:0] m,
                       input logic [3:0] idx, input logic [15:0] p, input string tag);
    exp_t e;
    logic rev, mod, dn, pre, upd;
    logic [15:0] st, np, len;
    reqValid = 1'b1; isWrite = w; isByte = by; modeSel = m; ptrIdx = idx; ptrVal = p;
    upd = (m >= 3'd1 && m <= 3'd4);
    dn  = (m == 3'd1 || m == 3'd3);
    pre = (m == 3'd3 || m == 3'd4);
    rev = mEn && w && !by && (m == 3'd2 || m == 3'd4) && idx == selReg && selReg != 4'd15;
    mod = modEn && idx == selReg && !rev;
    st  = by ? 16'd1 : 16'd2;
    np  = dn ? p - st : p + st;
    len = modHi - modLo + 16'd1;
    if (mod && !dn && np > modHi) np = np - len;
    if (mod && dn && np < modLo) np = np + len;
    if (rev) np = rcAdd(p, {mXb, 1'b0});
    if (!upd) np = p;
    e.ea  = pre ? np : p;
    if (rev) e.ea[0] = 1'b0;
    e.wb  = upd;
    e.ptr = np;
    e.tag = tag;
    lastWb = np;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (q.size() == 0) check(1'b0, "R1 unexpected result", eaOut, 16'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(eaOut == e.ea, {e.tag, " ea"}, eaOut, e.ea);
        check(wbEn == e.wb && (!e.wb || wbPtr == e.ptr), {e.tag, " wb"}, wbPtr, e.ptr);
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 16'h0, 16'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !wbEn && eaOut == 0 && wbPtr == 0, "R1 reset state", eaOut, 16'h0);

    // R2: enable reversal, modifier 8 (16-word buffer)
    selReg = 4'd3;
    ctrlWr = 1'b1; ctrlData = 16'h8008;
    @(negedge clk); ctrlWr = 1'b0; mEn = 1'b1; mXb = 15'd8;

    // R4 R5: full bit-reversed walk, post-increment
    p = 16'h0200;
    for (int i = 0; i < 16; i++) begin
      issue(1'b1, 1'b0, 3'd2, 4'd3, p, "R4 rev walk");
      p = lastWb;
    end
    idle(1);
    check(p == 16'h0200, "R4 walk returns to base", p, 16'h0200);

    issue(1'b1, 1'b0, 3'd2, 4'd3, 16'h0000, "R4 step 0->8");
    check(lastWb == 16'h0010, "R4 first reversed step", lastWb, 16'h0010);
    issue(1'b1, 1'b0, 3'd4, 4'd3, 16'h0010, "R5 pre-inc rev ea");
    issue(1'b1, 1'b0, 3'd2, 4'd3, 16'h1001, "R5 odd ptr lsb cleared");
    // R3: qualifying conditions not all met
    issue(1'b1, 1'b1, 3'd2, 4'd3, 16'h0040, "R3 byte write normal");
    issue(1'b0, 1'b0, 3'd2, 4'd3, 16'h0040, "R3 read normal");
    issue(1'b1, 1'b0, 3'd3, 4'd3, 16'h0040, "R3 pre-dec write normal");
    issue(1'b1, 1'b0, 3'd2, 4'd5, 16'h0040, "R3 other register normal");
    idle(2);
    // R10: stack register
    selReg = 4'd15;
    issue(1'b1, 1'b0, 3'd2, 4'd15, 16'h0800, "R10 stack not reversed");
    // R6 R7: normal modes
    issue(1'b0, 1'b0, 3'd1, 4'd15, 16'h0800, "R6 post-dec word");
    issue(1'b0, 1'b1, 3'd4, 4'd2, 16'h0801, "R6 pre-inc byte");
    issue(1'b0, 1'b0, 3'd0, 4'd2, 16'h0A0A, "R7 plain indirect");
    issue(1'b1, 1'b0, 3'd6, 4'd2, 16'h0B0B, "R7 unused code");
    idle(1);

    // R2: control write with a request in the same cycle uses old value
    selReg = 4'd3;
    ctrlWr = 1'b1; ctrlData = 16'h0008;
    issue(1'b1, 1'b0, 3'd2, 4'd3, 16'h0000, "R2 same-cycle old enable");
    ctrlWr = 1'b0; mEn = 1'b0;
    idle(1);
    issue(1'b1, 1'b0, 3'd2, 4'd3, 16'h0000, "R2 disabled normal");

    // R8: modulo
    modEn = 1'b1; modLo = 16'h0100; modHi = 16'h010F;
    issue(1'b1, 1'b0, 3'd2, 4'd3, 16'h010E, "R8 wrap above hi");
    check(lastWb == 16'h0100, "R8 wrap value", lastWb, 16'h0100);
    issue(1'b0, 1'b1, 3'd4, 4'd3, 16'h010E, "R8 exact hi kept");
    issue(1'b0, 1'b0, 3'd1, 4'd3, 16'h0100, "R8 wrap below lo");
    issue(1'b0, 1'b0, 3'd4, 4'd3, 16'h010F, "R8 jump beyond hi");
    idle(1);

    // R9: reversal beats modulo on writes, reads keep modulo
    ctrlWr = 1'b1; ctrlData = 16'h8004;
    @(negedge clk); ctrlWr = 1'b0; mEn = 1'b1; mXb = 15'd4;
    idle(1);
    issue(1'b1, 1'b0, 3'd2, 4'd3, 16'h010C, "R9 write reversed");
    issue(1'b0, 1'b0, 3'd2, 4'd3, 16'h010E, "R9 read modulo");
    idle(3);

    check(q.size() == 0, "R1 all results seen", 16'(q.size()), 16'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule